// File: doc/BRIEF.md
# Two-Wire Serial Shift Interface with Busy Handshake and Address Wake-Up

This block moves one byte at a time over a two-wire serial bus. The bus has a serial clock line and an open-drain data line. A register write loads the transfer byte into the shift register. The block starts the transfer only when the channel is enabled, the clock is idle and the data line reads high (ready). It then shifts eight bits, most significant bit first. When the last bit has been sampled it raises a sticky interrupt flag. The serial clock comes either from the block's own divider or from the bus clock pin, selected by a configuration input.

The data line also carries a busy/ready handshake. A remote slave holds the line low while it is busy, and a pending write waits until the line reads high. The block can also pull the line low itself with a busy-set command. A busy-clear command does not release the line at once: the release waits for the next falling edge of the serial clock. If wake-up mode is turned on before that edge, the line is not released.

In wake-up mode the block never drives data, so its output stays high impedance. The interrupt is raised only when the first byte received after a bus release equals the block's own address. A bus release is noted either by an external release pulse or by a release-trigger strobe from a register write.

Top module: `ssi_bus_if`

## Requirements
- R1: A write with `en`=1 starts a transfer once the clock is idle and `sda_level` is 1. The clock is idle when `sck_o` is high and no transfer runs (`int_clk`=1), or when `sck_i` is high (`int_clk`=0). While `sck_i` stays low in external mode, `xfer_active` stays 0.
- R2: A write made while `en`=0 starts no transfer, even after `en` later goes to 1. The written byte is still loaded and shows on `rx_data`.
- R3: Bits leave MSB first. The data bit changes after a serial falling edge: `sda_oe`=1 means a 0 is driven. Input is sampled on the rising edge. The received byte equals the wired-AND of the sent byte and the remote byte.
- R4: After the eighth rising edge, `xfer_active` returns to 0. Outside wake-up mode, `irq` goes to 1 and stays 1 until an `irq_clr` pulse.
- R5: A write made while the data line is held low by a remote slave is kept. The transfer starts by itself once the line reads high.
- R6: While `wake`=1, the transfer data never drives the line: `sda_oe` stays 0 unless busy is driven.
- R7: While `wake`=1, `irq` is set at the end of a byte only if the release flag was 1 and the received byte equals `own_addr`. The release flag clears at the end of every byte.
- R8: A pulse on `bus_rel` or on `rel_trig` sets `rel_flag` to 1.
- R9: A `busy_set` pulse makes `sda_oe` 1. After a `busy_clr` pulse, `sda_oe` stays 1 until the next serial clock falling edge, and then goes to 0.
- R10: If `wake` is 1 at the falling edge that would end busy, busy stays driven. A new `busy_clr` is then needed.
- R11: `sda_level` shows the data line level, one clock cycle late.
- R12: In internal clock mode, `sck_o` idles high. A transfer produces exactly eight low pulses, each half period lasting `HALF_PERIOD` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| wake | input | 1 | Wake-up (address match) mode |
| int_clk | input | 1 | 1: use the internal serial clock divider; 0: use `sck_i` |
| wr_en | input | 1 | Shift register write strobe |
| wr_data | input | DATA_W | Byte to load |
| own_addr | input | DATA_W | Local address for wake-up match |
| rel_trig | input | 1 | Register strobe that forces a bus-release indication |
| bus_rel | input | 1 | Bus release detected pulse |
| busy_set | input | 1 | Command: drive busy on the data line |
| busy_clr | input | 1 | Command: release busy at the next falling edge |
| irq_clr | input | 1 | Clears the interrupt flag |
| sck_i | input | 1 | Serial clock line input |
| sda_i | input | 1 | Data line input |
| sck_o | output | 1 | Internal serial clock output, idle high |
| sda_oe | output | 1 | Open-drain pull-down enable for the data line |
| rx_data | output | DATA_W | Shift register contents |
| irq | output | 1 | Transfer-complete / address-match interrupt flag |
| rel_flag | output | 1 | Bus release seen since the last byte |
| sda_level | output | 1 | Sampled data line level |
| xfer_active | output | 1 | Transfer in progress |

## Verification
The assertions check on every cycle that:
- a pending start exists only after a write made with `en` set;
- a transfer begins only with a pending write and a high data line;
- the interrupt rises only after a byte ends, and in wake-up mode only with a set release flag and a received byte equal to `own_addr`;
- busy falls only at a serial falling edge while wake-up mode is off;
- the internal clock idles high between transfers.

The bench's scenarios are the only place that show several other behaviours. These are the bit order and the wired-AND value of the received data, and the deferral of a write through a remote busy or a low clock. They also include the enable-order rule, the exact count of internal clock pulses, and the held busy when wake-up mode is turned on inside the release window.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

    // One serial clock event, decoded from either clock source
    typedef struct packed {
        logic fall;
        logic rise;
    } sck_ev_t;

    typedef enum logic {
        XF_IDLE  = 1'b0,
        XF_SHIFT = 1'b1
    } xfer_st_e;

    // Open-drain pull-down request: transfer data drives only outside wake-up
    function automatic logic pull_low(input logic busy, input logic wake, input logic bit_out);
        return busy | (~wake & ~bit_out);
    endfunction

endpackage

// File: rtl/ssi_sync.sv
module ssi_sync
    import ssi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sck_i,
    input  logic    sda_i,
    output logic    sck_s,
    output logic    sda_s,
    output sck_ev_t ev
);
    logic sck_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s <= 1'b1;
            sck_p <= 1'b1;
            sda_s <= 1'b1;
        end else begin
            sck_s <= sck_i;
            sck_p <= sck_s;
            sda_s <= sda_i;
        end
    end

    always_comb begin
        ev.fall = sck_p & ~sck_s;
        ev.rise = ~sck_p & sck_s;
    end
endmodule

// File: rtl/ssi_clkgen.sv
module ssi_clkgen
    import ssi_pkg::*;
#(
    parameter int HALF_PERIOD = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    output logic    sck_o,
    output sck_ev_t ev
);
    localparam int CW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run & (cnt == CW'(HALF_PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            sck_o <= 1'b1;
        end else if (tick) begin
            cnt   <= '0;
            sck_o <= ~sck_o;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        ev.fall = tick & sck_o;
        ev.rise = tick & ~sck_o;
    end
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter
    import ssi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              start,
    input  sck_ev_t           ev,
    input  logic              sda_s,
    output logic [DATA_W-1:0] data,
    output logic              bit_out,
    output logic              active,
    output logic              done
);
    localparam int CW = $clog2(DATA_W);

    xfer_st_e      st;
    logic [CW-1:0] cnt;

    assign active = (st == XF_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= XF_IDLE;
            data    <= '0;
            bit_out <= 1'b1;
            done    <= 1'b0;
            cnt     <= '0;
        end else begin
            done <= 1'b0;
            if (st == XF_IDLE) begin
                if (start) begin
                    st      <= XF_SHIFT;
                    cnt     <= '0;
                    bit_out <= 1'b1;
                end else if (load) begin
                    data <= ld_data;
                end
            end else begin
                if (ev.fall) begin
                    bit_out <= data[DATA_W-1];
                end
                if (ev.rise) begin
                    data <= {data[DATA_W-2:0], sda_s};
                    if (cnt == CW'(DATA_W - 1)) begin
                        st      <= XF_IDLE;
                        done    <= 1'b1;
                        bit_out <= 1'b1;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ssi_busy.sv
module ssi_busy (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic fall,
    input  logic wake,
    output logic drv
);
    logic clr_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv      <= 1'b0;
            clr_pend <= 1'b0;
        end else if (set) begin
            drv      <= 1'b1;
            clr_pend <= 1'b0;
        end else if (fall && clr_pend) begin
            clr_pend <= 1'b0;
            if (!wake) drv <= 1'b0;
        end else if (clr && drv) begin
            clr_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/ssi_bus_if.sv
module ssi_bus_if
    import ssi_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_PERIOD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wake,
    input  logic              int_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] own_addr,
    input  logic              rel_trig,
    input  logic              bus_rel,
    input  logic              busy_set,
    input  logic              busy_clr,
    input  logic              irq_clr,
    input  logic              sck_i,
    input  logic              sda_i,
    output logic              sck_o,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq,
    output logic              rel_flag,
    output logic              sda_level,
    output logic              xfer_active
);
    sck_ev_t ext_ev, int_ev, ev;
    logic    sck_s, sda_s;
    logic    active, done, bit_out, busy_drv;
    logic    pend, start, clk_idle, fall_ev;

    ssi_sync i_sync (
        .clk(clk), .rst(rst), .sck_i(sck_i), .sda_i(sda_i),
        .sck_s(sck_s), .sda_s(sda_s), .ev(ext_ev)
    );

    ssi_clkgen #(.HALF_PERIOD(HALF_PERIOD)) i_clkgen (
        .clk(clk), .rst(rst), .run(active & int_clk),
        .sck_o(sck_o), .ev(int_ev)
    );

    assign ev       = int_clk ? int_ev : ext_ev;
    assign fall_ev  = ev.fall;
    assign clk_idle = int_clk ? sck_o : sck_s;
    assign start    = pend & ~active & clk_idle & sda_s;

    ssi_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk(clk), .rst(rst), .load(wr_en), .ld_data(wr_data),
        .start(start), .ev(ev), .sda_s(sda_s),
        .data(rx_data), .bit_out(bit_out), .active(active), .done(done)
    );

    ssi_busy i_busy (
        .clk(clk), .rst(rst), .set(busy_set), .clr(busy_clr),
        .fall(fall_ev), .wake(wake), .drv(busy_drv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            rel_flag <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (start || !en)
                pend <= 1'b0;
            else if (wr_en && !active)
                pend <= 1'b1;

            if (bus_rel || rel_trig)
                rel_flag <= 1'b1;
            else if (done)
                rel_flag <= 1'b0;

            if (done && (!wake || (rel_flag && rx_data == own_addr)))
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
        end
    end

    assign sda_oe      = pull_low(busy_drv, wake, bit_out);
    assign sda_level   = sda_s;
    assign xfer_active = active;
endmodule

// File: rtl/ssi_checker.sv
module ssi_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              wake,
    input logic              wr_en,
    input logic              irq,
    input logic              done,
    input logic              busy_drv,
    input logic              fall_ev,
    input logic              active,
    input logic              pend,
    input logic              sda_level,
    input logic              rel_flag,
    input logic              int_clk,
    input logic              sck_o,
    input logic [DATA_W-1:0] rx_data,
    input logic [DATA_W-1:0] own_addr
);
    // R2: a start can be pending only after a write made while enabled
    a_r2_pend_needs_en: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(en && wr_en));

    // R1 / R5: a transfer begins only from a pending write with a ready line
    a_r1_start_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(pend && sda_level));

    // R4: interrupt rises only right after a byte ends
    a_r4_irq_after_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(done));

    // R7: in wake-up mode an interrupt needs the release flag and an address match
    a_r7_wake_match: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && $past(wake)) |-> $past(rel_flag && rx_data == own_addr));

    // R9 / R10: busy ends only at a serial falling edge with wake-up off
    a_r9_busy_release_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_drv) |-> $past(fall_ev && !wake));

    // R12: internal clock idles high between transfers
    a_r12_idle_high: assert property (@(posedge clk) disable iff (rst)
        (int_clk && !active && !$past(active)) |-> sck_o);
endmodule

bind ssi_bus_if ssi_checker #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst(rst), .en(en), .wake(wake), .wr_en(wr_en),
    .irq(irq), .done(done), .busy_drv(busy_drv), .fall_ev(fall_ev),
    .active(active), .pend(pend), .sda_level(sda_level),
    .rel_flag(rel_flag), .int_clk(int_clk), .sck_o(sck_o),
    .rx_data(rx_data), .own_addr(own_addr)
);

// File: tb/test_ssi_bus_if.sv
module test_ssi_bus_if;
    localparam int W = 8;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, wake = 1'b0, int_clk = 1'b0, wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] own_addr = 8'h5A;
    logic rel_trig = 1'b0, bus_rel = 1'b0, busy_set = 1'b0, busy_clr = 1'b0, irq_clr = 1'b0;
    logic sck_i = 1'b1;
    logic rbit = 1'b1, rbusy = 1'b0;
    logic sda_i;
    logic sck_o, sda_oe, irq, rel_flag, sda_level, xfer_active;
    logic [W-1:0] rx_data;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    // Wired-AND data line: this block, remote data and remote busy
    assign sda_i = ~sda_oe & rbit & ~rbusy;

    ssi_bus_if #(.DATA_W(W), .HALF_PERIOD(HALF)) i_ssi_bus_if (
        .clk(clk), .rst(rst), .en(en), .wake(wake), .int_clk(int_clk),
        .wr_en(wr_en), .wr_data(wr_data), .own_addr(own_addr),
        .rel_trig(rel_trig), .bus_rel(bus_rel), .busy_set(busy_set),
        .busy_clr(busy_clr), .irq_clr(irq_clr), .sck_i(sck_i), .sda_i(sda_i),
        .sck_o(sck_o), .sda_oe(sda_oe), .rx_data(rx_data), .irq(irq),
        .rel_flag(rel_flag), .sda_level(sda_level), .xfer_active(xfer_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [W-1:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    // External clock byte; checks the driven bit after each falling edge
    task automatic xfer_ext(input logic [W-1:0] tx, input logic [W-1:0] rb, input logic wk);
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk); sck_i = 1'b0; rbit = rb[i];
            wait_n(6);
            if (wk) check("R6 wake data drive", sda_oe, 1'b0);
            else    check("R3 msb-first bit", sda_oe, !tx[i]);
            sck_i = 1'b1;
            wait_n(6);
        end
        rbit = 1'b1;
        wait_n(4);
    endtask

    task automatic t_reset();
        check("R4 reset irq", irq, 1'b0);
        check("R9 reset sda_oe", sda_oe, 1'b0);
        check("R12 reset sck_o", sck_o, 1'b1);
        check("R8 reset rel_flag", rel_flag, 1'b0);
        check("R4 reset active", xfer_active, 1'b0);
    endtask

    task automatic t_enable_order();
        en = 1'b0;
        write_byte(8'hA5);
        en = 1'b1;
        wait_n(8);
        check("R2 no start after late enable", xfer_active, 1'b0);
        check("R2 byte loaded", rx_data, 8'hA5);
        check("R2 no irq", irq, 1'b0);
    endtask

    task automatic t_basic();
        @(negedge clk); sck_i = 1'b0;
        write_byte(8'hA5);
        wait_n(8);
        check("R1 held while clock low", xfer_active, 1'b0);
        sck_i = 1'b1;
        wait_n(4);
        check("R1 start on idle clock", xfer_active, 1'b1);
        xfer_ext(8'hA5, 8'h3C, 1'b0);
        check("R3 wired-AND data", rx_data, 8'hA5 & 8'h3C);
        check("R4 irq set", irq, 1'b1);
        check("R4 stopped", xfer_active, 1'b0);
        wait_n(10);
        check("R4 irq sticky", irq, 1'b1);
        clear_irq();
        check("R4 irq cleared", irq, 1'b0);
    endtask

    task automatic t_busy_hold();
        @(negedge clk); rbusy = 1'b1;
        wait_n(3);
        check("R11 level low", sda_level, 1'b0);
        write_byte(8'h96);
        wait_n(8);
        check("R5 held while busy", xfer_active, 1'b0);
        rbusy = 1'b0;
        wait_n(4);
        check("R11 level high", sda_level, 1'b1);
        check("R5 start after ready", xfer_active, 1'b1);
        xfer_ext(8'h96, 8'hFF, 1'b0);
        check("R5 data after hold", rx_data, 8'h96);
        check("R5 irq", irq, 1'b1);
        clear_irq();
    endtask

    task automatic t_int_clock();
        int falls = 0;
        int low_cycles = 0;
        logic prev;
        @(negedge clk); int_clk = 1'b1;
        write_byte(8'hC3);
        prev = sck_o;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (prev && !sck_o) falls++;
            if (!sck_o) low_cycles++;
            prev = sck_o;
        end
        check("R12 eight pulses", falls, 8);
        check("R12 low time", low_cycles, 8 * HALF);
        check("R12 idle high", sck_o, 1'b1);
        check("R3 int-clock data", rx_data, 8'hC3);
        check("R4 int-clock irq", irq, 1'b1);
        int_clk = 1'b0;
        clear_irq();
    endtask

    task automatic t_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); rel_trig = 1'b1;
        @(negedge clk); rel_trig = 1'b0;
        check("R8 rel_trig sets flag", rel_flag, 1'b1);
        write_byte(8'h00);
        wait_n(3);
        check("R6 start in wake", xfer_active, 1'b1);
        xfer_ext(8'h00, 8'h5A, 1'b1);
        check("R7 match irq", irq, 1'b1);
        check("R7 received addr", rx_data, 8'h5A);
        check("R7 flag cleared", rel_flag, 1'b0);
        clear_irq();
        @(negedge clk); bus_rel = 1'b1;
        @(negedge clk); bus_rel = 1'b0;
        check("R8 bus_rel sets flag", rel_flag, 1'b1);
        write_byte(8'h00);
        wait_n(3);
        xfer_ext(8'h00, 8'h33, 1'b1);
        check("R7 mismatch no irq", irq, 1'b0);
        write_byte(8'h00);
        wait_n(3);
        xfer_ext(8'h00, 8'h5A, 1'b1);
        check("R7 no release no irq", irq, 1'b0);
        wake = 1'b0;
    endtask

    task automatic t_busy_release();
        @(negedge clk); busy_set = 1'b1;
        @(negedge clk); busy_set = 1'b0;
        check("R9 busy driven", sda_oe, 1'b1);
        @(negedge clk); busy_clr = 1'b1;
        @(negedge clk); busy_clr = 1'b0;
        wait_n(6);
        check("R9 busy held until fall", sda_oe, 1'b1);
        sck_i = 1'b0;
        wait_n(5);
        check("R9 busy released at fall", sda_oe, 1'b0);
        sck_i = 1'b1;
        wait_n(5);
        // R10: wake-up enabled inside the window
        busy_set = 1'b1;
        @(negedge clk); busy_set = 1'b0;
        @(negedge clk); busy_clr = 1'b1;
        @(negedge clk); busy_clr = 1'b0; wake = 1'b1;
        wait_n(2);
        sck_i = 1'b0;
        wait_n(5);
        check("R10 busy kept with wake", sda_oe, 1'b1);
        sck_i = 1'b1;
        wait_n(5);
        wake = 1'b0;
        busy_clr = 1'b1;
        @(negedge clk); busy_clr = 1'b0;
        wait_n(2);
        sck_i = 1'b0;
        wait_n(5);
        check("R10 released after new clear", sda_oe, 1'b0);
        sck_i = 1'b1;
        wait_n(5);
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        t_reset();
        t_enable_order();
        t_basic();
        t_busy_hold();
        t_int_clock();
        t_wake();
        t_busy_release();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule